// File: doc/BRIEF.md
# Serial Byte Transmitter with Clear-to-Send Pacing

This block turns bytes into asynchronous serial frames on one output line. Bytes are written into a small internal queue. A frame state machine pops them one at a time and shifts out a low start bit, eight data bits beginning with the least significant, an optional parity bit, and a high stop bit. Every bit lasts exactly one interval of the external bit-rate enable `baud_tick`, and a frame can only begin on a tick.

When pacing is switched on, a clear-to-send input (`cts_hold`, high means "hold") is passed through a two-stage synchronizer. It is looked at only when a new frame is about to start. A frame already on the line always completes. After that the line rests high until the hold is released, and then the next queued byte goes out with its start bit. When pacing is off, the hold input has no effect and queued bytes leave back to back.

The state machine has five states. It starts in IDLE. On a tick with a byte ready and no hold, IDLE goes to START. After one tick, START goes to DATA. DATA leaves on the eighth tick: to PARITY when parity is enabled, otherwise to STOP. PARITY goes to STOP after one tick. STOP ends on the next tick: it returns to START when another frame may launch, otherwise to IDLE.

Top module: `uart_tx_flow`

## Requirements
- R1: A frame is one low start bit, then data bits D0 first through D7, then one high stop bit. Each bit holds the line for exactly one `baud_tick` interval.
- R2: With `par_en`=1, a parity bit sits between D7 and the stop bit. With `par_odd`=0 it is the XOR of the data bits (even parity). With `par_odd`=1 it is the inverse of that XOR (odd parity).
- R3: With `par_en`=0, the stop bit follows D7 directly.
- R4: While no frame is on the line, `tx_line` is 1. After reset, `tx_line`=1 and `tx_busy`=0.
- R5: With `flow_en`=1 and `cts_hold`=1, no new frame starts. A frame already in progress when the hold rises is sent in full, and then the line stays at 1.
- R6: With `flow_en`=1, once `cts_hold` returns to 0, the next queued byte is sent, starting with its start bit.
- R7: With `flow_en`=0, `cts_hold` is ignored. While the queue holds bytes, a stop bit is followed at once by the next start bit.
- R8: `tx_busy` is 1 from the first cycle of a start bit until the stop bit's interval ends. It is 0 whenever the line is idle.
- R9: Bytes leave in the order they were written. `fifo_full` is 1 when the queue holds DEPTH bytes (8 by default), and a write while full is dropped.
- R10: A frame's start bit begins only in the cycle after a `baud_tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | Queue holds DEPTH bytes |
| baud_tick | input | 1 | One-cycle pulse per bit interval |
| par_en | input | 1 | Insert a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| flow_en | input | 1 | Enable clear-to-send pacing |
| cts_hold | input | 1 | Asynchronous hold request, 1 = stop |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | A frame is on the line |

## Verification
Two events can fall on the same tick: the end of a stop bit and the decision whether to launch the next frame. Which way that decision goes depends on the queue level and on the synchronized hold at that moment. The bench sets up both cases. In one, the hold is raised during a start bit while a second byte is queued; the bench expects the first frame to arrive intact, followed by a long stretch of mark with `tx_busy` low. In the other, pacing is off and the hold is high; the bench expects the next start bit in the very cycle after the stop bit's interval ends.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;
endpackage

// File: rtl/tx_byte_queue.sv
module tx_byte_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    p_drop_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full && $stable(wr_ptr));
    p_no_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/cts_synchronizer.sv
module cts_synchronizer #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], async_in};
    end

    assign sync_out = sr[STAGES-1];
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
    import uart_tx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         baud_tick,
    input  logic         par_en,
    input  logic         par_odd,
    input  logic         flow_en,
    input  logic         hold_sync,
    input  logic         q_empty,
    input  logic [W-1:0] q_head,
    output logic         pop,
    output logic         tx,
    output logic         busy
);
    localparam int CNT_W = $clog2(W);

    tx_state_e        state, state_nx;
    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic             par_bit;
    logic             launch;

    assign launch = baud_tick && !q_empty && !(flow_en && hold_sync);

    always_comb begin
        state_nx = state;
        pop      = 1'b0;
        unique case (state)
            TX_IDLE: if (launch) begin
                state_nx = TX_START;
                pop      = 1'b1;
            end
            TX_START: if (baud_tick) state_nx = TX_DATA;
            TX_DATA: if (baud_tick && bit_cnt == CNT_W'(W-1))
                state_nx = par_en ? TX_PARITY : TX_STOP;
            TX_PARITY: if (baud_tick) state_nx = TX_STOP;
            TX_STOP: if (launch) begin
                state_nx = TX_START;
                pop      = 1'b1;
            end else if (baud_tick) begin
                state_nx = TX_IDLE;
            end
            default: state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
            par_bit <= 1'b0;
        end else begin
            state <= state_nx;
            if (pop) begin
                shreg   <= q_head;
                par_bit <= (^q_head) ^ par_odd;
                bit_cnt <= '0;
            end else if (state == TX_DATA && baud_tick) begin
                shreg   <= shreg >> 1;
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        tx   = 1'b1;
        busy = 1'b1;
        unique case (state)
            TX_IDLE:   busy = 1'b0;
            TX_START:  tx = 1'b0;
            TX_DATA:   tx = shreg[0];
            TX_PARITY: tx = par_bit;
            TX_STOP:   tx = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    p_bit_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(tx));
    p_mark_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);
    p_start_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(baud_tick) && !tx);
    p_hold_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && flow_en && hold_sync) |=> state == TX_IDLE);
    p_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_STOP && baud_tick && !q_empty && !flow_en) |=> state == TX_START);
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow #(
    parameter int W       = 8,
    parameter int DEPTH   = 8,
    parameter int SYNC_FF = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         fifo_full,
    input  logic         baud_tick,
    input  logic         par_en,
    input  logic         par_odd,
    input  logic         flow_en,
    input  logic         cts_hold,
    output logic         tx_line,
    output logic         tx_busy
);
    logic         q_empty, q_pop, hold_s;
    logic [W-1:0] q_head;

    tx_byte_queue #(.W(W), .DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
        .pop(q_pop), .head(q_head), .empty(q_empty), .full(fifo_full)
    );

    cts_synchronizer #(.STAGES(SYNC_FF)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cts_hold), .sync_out(hold_s)
    );

    tx_frame_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .par_en(par_en),
        .par_odd(par_odd), .flow_en(flow_en), .hold_sync(hold_s),
        .q_empty(q_empty), .q_head(q_head), .pop(q_pop),
        .tx(tx_line), .busy(tx_busy)
    );
endmodule

// File: tb/test_uart_tx_flow.sv
module test_uart_tx_flow;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fifo_full;
    logic       baud_tick = 1'b0;
    logic       par_en = 1'b0, par_odd = 1'b0, flow_en = 1'b0, cts_hold = 1'b0;
    logic       tx_line, tx_busy;
    int         n_chk = 0, n_fail = 0, cyc = 0;
    bit         done = 1'b0;

    uart_tx_flow i_uart_tx_flow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_full(fifo_full), .baud_tick(baud_tick), .par_en(par_en),
        .par_odd(par_odd), .flow_en(flow_en), .cts_hold(cts_hold),
        .tx_line(tx_line), .tx_busy(tx_busy)
    );

    initial forever #5 clk = ~clk;

    // bit-rate enable: one pulse every 4 clocks
    initial forever begin
        @(negedge clk);
        cyc++;
        baud_tick = (cyc % 4 == 0);
    end

    task automatic step(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    // wait for a start bit, then sample mid-bit; ends at mid stop bit
    task automatic recv(input bit use_par, output logic [7:0] d, output logic p,
                        output logic stp, output bit found, output int phase);
        int t = 0;
        found = 1'b0; d = '0; p = 1'b0; stp = 1'b0; phase = -1;
        while (tx_line && t < 400) begin step(1); t++; end
        if (tx_line) return;
        found = 1'b1;
        phase = cyc % 4;
        step(2);
        chk(tx_line == 1'b0 && tx_busy, "R1 start bit", tx_line, 0);
        for (int i = 0; i < 8; i++) begin
            step(4);
            d[i] = tx_line;
        end
        if (use_par) begin step(4); p = tx_line; end
        step(4);
        stp = tx_line;
        chk(tx_busy == 1'b1, "R8 busy during stop", tx_busy, 1);
    endtask

    task automatic t_reset;
        chk(tx_line == 1'b1, "R4 reset line", tx_line, 1);
        chk(tx_busy == 1'b0, "R4 reset busy", tx_busy, 0);
        chk(fifo_full == 1'b0, "R9 reset full", fifo_full, 0);
    endtask

    task automatic t_plain_r3;
        logic [7:0] d; logic p, s; bit f; int ph;
        par_en = 1'b0; flow_en = 1'b0;
        put(8'h33);
        recv(1'b0, d, p, s, f, ph);
        chk(f && d == 8'h33, "R1 data D0 first", d, 8'h33);
        chk(s == 1'b1, "R3 stop right after D7", s, 1);
        chk(ph == 1, "R10 start after tick", ph, 1);
        step(2);
        chk(tx_busy == 1'b0 && tx_line, "R8 busy drops after stop", tx_busy, 0);
    endtask

    task automatic t_parity_r2(input bit odd, input logic [7:0] b);
        logic [7:0] d; logic p, s; bit f; int ph;
        par_en = 1'b1; par_odd = odd; flow_en = 1'b0;
        put(b);
        recv(1'b1, d, p, s, f, ph);
        chk(f && d == b, "R2 data", d, b);
        chk(p == ((^b) ^ odd), "R2 parity bit", p, (^b) ^ odd);
        chk(s == 1'b1, "R1 stop bit", s, 1);
        step(2);
        chk(tx_busy == 1'b0, "R8 idle after parity frame", tx_busy, 0);
        par_en = 1'b0;
    endtask

    task automatic t_back_to_back_r7;
        logic [7:0] d; logic p, s; bit f; int ph;
        flow_en = 1'b0; cts_hold = 1'b1;
        put(8'hA5); put(8'h5A);
        recv(1'b0, d, p, s, f, ph);
        chk(f && d == 8'hA5, "R7 first byte with hold ignored", d, 8'hA5);
        step(2);
        chk(tx_line == 1'b0 && tx_busy, "R7 next start follows stop", tx_line, 0);
        recv(1'b0, d, p, s, f, ph);
        chk(f && d == 8'h5A && s, "R7 second byte", d, 8'h5A);
        step(4);
        cts_hold = 1'b0;
    endtask

    task automatic t_cts_r5_r6;
        logic [7:0] d; logic p, s; bit f; int ph, bad;
        int t = 0;
        flow_en = 1'b1; cts_hold = 1'b0;
        step(4);
        put(8'hC3);
        while (!tx_busy && t < 100) begin step(1); t++; end
        cts_hold = 1'b1;
        put(8'h3C);
        recv(1'b0, d, p, s, f, ph);
        chk(f && d == 8'hC3 && s, "R5 frame in flight completes", d, 8'hC3);
        bad = 0;
        for (int i = 0; i < 48; i++) begin
            step(1);
            if (!tx_line || tx_busy) bad++;
        end
        chk(bad == 0, "R5 line parked at mark under hold", bad, 0);
        cts_hold = 1'b0;
        recv(1'b0, d, p, s, f, ph);
        chk(f && d == 8'h3C && s, "R6 next byte after release", d, 8'h3C);
        step(2);
    endtask

    task automatic t_fifo_r9;
        logic [7:0] d; logic p, s; bit f; int ph, bad;
        flow_en = 1'b1; cts_hold = 1'b1;
        step(4);
        for (int i = 0; i < 9; i++) put(8'h10 + 8'(i));
        chk(fifo_full == 1'b1, "R9 full at depth", fifo_full, 1);
        chk(tx_busy == 1'b0, "R5 held queue not sent", tx_busy, 0);
        cts_hold = 1'b0;
        for (int i = 0; i < 8; i++) begin
            recv(1'b0, d, p, s, f, ph);
            chk(f && d == 8'h10 + 8'(i), "R9 order", d, 8'h10 + i);
        end
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (!tx_line) bad++;
        end
        chk(bad == 0, "R9 write while full dropped", bad, 0);
        chk(fifo_full == 1'b0, "R9 full clears", fifo_full, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_plain_r3();
        t_parity_r2(1'b0, 8'hB7);
        t_parity_r2(1'b1, 8'hB7);
        t_parity_r2(1'b1, 8'h81);
        t_back_to_back_r7();
        t_cts_r5_r6();
        t_fifo_r9();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule